// File: doc/BRIEF.md
# Two-Phase Configuration Cycle Sequencer

This block carries out one configuration access for a host through two separate downstream locations. It first writes an address/control word that names the target register, function and device. It then reads or writes a 32-bit data window. Finally it writes zero to the control register, so that the window goes back to ordinary I/O use. A request that names a field value out of range, or that names the reserved slot on a local-bus cycle, gets a not-found response and starts no cycle at all.

Reads return the addressed byte lane, half-word or full dword of the window dword. Writes are read-merge-write: the window dword is fetched, the new bytes are placed into it, and the whole dword is written back. The device gives no completion indication, so the sequencer then waits a fixed time before it clears the control register. That time is a parameter in microseconds, converted to cycles from the clock frequency. While a transaction is in flight the block reports busy and ignores new requests.

Top module: `cfg_cycle_seq`

## Requirements
- R1: A request is refused with status 1 (not found) when the slot is above 31, the function is above 7, or the dword number `req_where[9:2]` is above 63. The response comes one cycle after the request, and no control or window strobe is issued.
- R2: The control word carries a fixed pattern. Bit 31 is the config-select flag and bit 30 is the use-register flag, both set. Bits [15:11] hold the slot, bits [10:8] the function and bits [7:2] the dword number. All other bits are zero, apart from bit 0.
- R3: Bit 0 of the control word is 1 for a request with `req_type1` set, meaning it does not target the local bus. It is 0 for a local-bus request.
- R4: A read writes the control word, reads the window in the next cycle, and writes zero to the control register three cycles after the control word. The response follows one cycle later, five cycles after the request.
- R5: A write performs one window read and then one window write of the merged dword. After that it waits exactly WAIT cycles, equal to CLK_HZ/1000 × WAIT_US/1000, before it writes zero to the control register. The zero write therefore lands WAIT+1 cycles after the window write.
- R6: On a type-0 request the reserved slot (parameter, default 20) is refused as not found. The same slot on a type-1 request is accepted.
- R7: The read result is the window dword shifted right by 8×`req_where[1:0]`, then masked to 8 bits (size code 0) or 16 bits (size code 1). Size codes 2 and 3 return the whole dword and ignore the offset. Lanes never wrap, so a half-word at offset 3 returns only the top byte.
- R8: A write replaces only the addressed lanes of the fetched dword, using the same size codes and offsets as R7. Bits of `req_wdata` above the access width are ignored, and a half-word at offset 3 changes only the top byte.
- R9: While `busy` is high, `req_valid` is ignored: no response, no strobe, no state change.
- R10: `resp_valid` is a single-cycle pulse per accepted or refused request, with status 0 for success. A write response carries zero data. After reset, `busy`, `resp_valid` and all downstream strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_type1 | input | 1 | 1 = target beyond the local bus |
| req_slot | input | 8 | Requested device slot |
| req_func | input | 8 | Requested function |
| req_where | input | 10 | Byte address: [9:2] dword number, [1:0] lane offset |
| req_size | input | 2 | 0 byte, 1 half-word, 2/3 dword |
| req_wdata | input | 32 | Write value, right-aligned |
| busy | output | 1 | Transaction in progress |
| resp_valid | output | 1 | Response pulse |
| resp_status | output | 1 | 0 success, 1 not found |
| resp_rdata | output | 32 | Read result |
| ctl_wr_en | output | 1 | Control register write strobe |
| ctl_wr_data | output | 32 | Control register write value |
| win_rd_en | output | 1 | Data window read strobe |
| win_rd_data | input | 32 | Window data, valid the cycle after win_rd_en |
| win_wr_en | output | 1 | Data window write strobe |
| win_wr_data | output | 32 | Window write value |

## Verification
The bench probes each range limit from both sides: slot 31, function 7 and dword 63 must pass, while 32, 8 and 64 must be refused. A design that truncated the wide inputs into the narrow fields would instead start a cycle against an aliased device. The reserved slot is tried with both cycle types, which exposes a rejection that ignores the type bit. Half-word lanes at offset 3 catch a design that wraps bytes around the dword. Write values with stray upper bits catch a merge that fails to mask. The blind wait is measured edge to edge, and a request sent mid-wait checks that the busy flag really blocks a second, overlapping control-register sequence.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_RD,
    ST_CAP,
    ST_WR,
    ST_WAIT,
    ST_CLR
  } seq_state_t;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_WORD3 = 2'b11
  } acc_size_t;

  localparam int CW_TYPE_BIT = 0;
  localparam int CW_REG_LSB  = 2;
  localparam int CW_FUNC_LSB = 8;
  localparam int CW_DEV_LSB  = 11;
  localparam int CW_USE_BIT  = 30;
  localparam int CW_SEL_BIT  = 31;

  localparam logic STAT_OK        = 1'b0;
  localparam logic STAT_NOT_FOUND = 1'b1;

endpackage

// File: rtl/cfg_req_decode.sv
module cfg_req_decode
  import cfg_seq_pkg::*;
#(
  parameter int          SLOT_W      = 5,
  parameter int          FUNC_W      = 3,
  parameter int          REG_W       = 6,
  parameter int          HOST_SLOT_W = 8,
  parameter int          HOST_FUNC_W = 8,
  parameter int          HOST_REG_W  = 8,
  parameter int unsigned RSV_SLOT    = 20
) (
  input  logic [HOST_SLOT_W-1:0] in_slot,
  input  logic [HOST_FUNC_W-1:0] in_func,
  input  logic [HOST_REG_W-1:0]  in_reg,
  input  logic                   in_type1,
  output logic                   acc_ok,
  output logic [31:0]            ctl_word
);

  localparam int unsigned SLOT_MAX = (1 << SLOT_W) - 1;
  localparam int unsigned FUNC_MAX = (1 << FUNC_W) - 1;
  localparam int unsigned REG_MAX  = (1 << REG_W) - 1;

  logic range_ok;
  logic rsv_hit;

  assign range_ok = (in_slot <= HOST_SLOT_W'(SLOT_MAX)) &&
                    (in_func <= HOST_FUNC_W'(FUNC_MAX)) &&
                    (in_reg  <= HOST_REG_W'(REG_MAX));
  assign rsv_hit  = !in_type1 && (in_slot == HOST_SLOT_W'(RSV_SLOT));
  assign acc_ok   = range_ok && !rsv_hit;

  always_comb begin
    ctl_word                            = '0;
    ctl_word[CW_REG_LSB  +: REG_W]      = in_reg[REG_W-1:0];
    ctl_word[CW_FUNC_LSB +: FUNC_W]     = in_func[FUNC_W-1:0];
    ctl_word[CW_DEV_LSB  +: SLOT_W]     = in_slot[SLOT_W-1:0];
    ctl_word[CW_TYPE_BIT]               = in_type1;
    ctl_word[CW_USE_BIT]                = 1'b1;
    ctl_word[CW_SEL_BIT]                = 1'b1;
  end

endmodule

// File: rtl/cfg_lane_align.sv
module cfg_lane_align
  import cfg_seq_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] dword,
  input  logic [DW-1:0] wval,
  input  logic [1:0]    off,
  input  acc_size_t     size,
  output logic [DW-1:0] rd_ext,
  output logic [DW-1:0] wr_merged
);

  localparam int SH_W = $clog2(DW);

  logic [DW-1:0]   lane_mask;
  logic [DW-1:0]   pos_mask;
  logic [SH_W-1:0] eff_sh;

  always_comb begin
    case (size)
      SZ_BYTE: begin
        lane_mask = DW'(32'h0000_00FF);
        eff_sh    = SH_W'({off, 3'b000});
      end
      SZ_HALF: begin
        lane_mask = DW'(32'h0000_FFFF);
        eff_sh    = SH_W'({off, 3'b000});
      end
      default: begin
        lane_mask = '1;
        eff_sh    = '0;
      end
    endcase
  end

  assign pos_mask  = lane_mask << eff_sh;
  assign rd_ext    = (dword >> eff_sh) & lane_mask;
  assign wr_merged = (dword & ~pos_mask) | ((wval & lane_mask) << eff_sh);

endmodule

// File: rtl/cfg_wait_timer.sv
module cfg_wait_timer #(
  parameter int unsigned CYCLES = 62500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);

  localparam int unsigned CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;

  assign done = run_q && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (start) begin
      cnt_d = LOAD;
      run_d = 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_d = 1'b0;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  AST_TIMER_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !run_q); // R5

endmodule

// File: rtl/cfg_cycle_seq.sv
module cfg_cycle_seq
  import cfg_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 125_000_000,
  parameter int unsigned WAIT_US     = 500,
  parameter int          SLOT_W      = 5,
  parameter int          FUNC_W      = 3,
  parameter int          REG_W       = 6,
  parameter int          HOST_SLOT_W = 8,
  parameter int          HOST_FUNC_W = 8,
  parameter int          WHERE_W     = 10,
  parameter int unsigned RSV_SLOT    = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic                   req_type1,
  input  logic [HOST_SLOT_W-1:0] req_slot,
  input  logic [HOST_FUNC_W-1:0] req_func,
  input  logic [WHERE_W-1:0]     req_where,
  input  logic [1:0]             req_size,
  input  logic [31:0]            req_wdata,
  output logic                   busy,
  output logic                   resp_valid,
  output logic                   resp_status,
  output logic [31:0]            resp_rdata,
  output logic                   ctl_wr_en,
  output logic [31:0]            ctl_wr_data,
  output logic                   win_rd_en,
  input  logic [31:0]            win_rd_data,
  output logic                   win_wr_en,
  output logic [31:0]            win_wr_data
);

  localparam int          HOST_REG_W = WHERE_W - 2;
  localparam int unsigned WAIT_RAW   = (CLK_HZ / 1000) * WAIT_US / 1000;
  localparam int unsigned WAIT_CYC   = (WAIT_RAW < 1) ? 1 : WAIT_RAW;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       arst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign arst_n = rst_sync_q[1];

  seq_state_t  state_q, state_d;
  logic        wr_q;
  logic [1:0]  off_q;
  acc_size_t   size_q;
  logic [31:0] wdata_q;
  logic [31:0] ctl_q;
  logic [31:0] dw_q;
  logic        resp_valid_q, resp_valid_d;
  logic        resp_status_q, resp_status_d;
  logic [31:0] resp_rdata_q, resp_rdata_d;

  logic        acc_ok;
  logic [31:0] ctl_word;
  logic [31:0] rd_ext;
  logic [31:0] wr_merged;
  logic        wait_done;
  logic        idle;
  logic        ld_req;
  logic        reject;
  logic        cap_en;

  cfg_req_decode #(
    .SLOT_W     (SLOT_W),
    .FUNC_W     (FUNC_W),
    .REG_W      (REG_W),
    .HOST_SLOT_W(HOST_SLOT_W),
    .HOST_FUNC_W(HOST_FUNC_W),
    .HOST_REG_W (HOST_REG_W),
    .RSV_SLOT   (RSV_SLOT)
  ) u_decode (
    .in_slot (req_slot),
    .in_func (req_func),
    .in_reg  (req_where[WHERE_W-1:2]),
    .in_type1(req_type1),
    .acc_ok  (acc_ok),
    .ctl_word(ctl_word)
  );

  cfg_lane_align #(.DW(32)) u_align (
    .dword    (dw_q),
    .wval     (wdata_q),
    .off      (off_q),
    .size     (size_q),
    .rd_ext   (rd_ext),
    .wr_merged(wr_merged)
  );

  cfg_wait_timer #(.CYCLES(WAIT_CYC)) u_timer (
    .clk  (clk),
    .rst_n(arst_n),
    .start(state_q == ST_WR),
    .done (wait_done)
  );

  assign idle   = (state_q == ST_IDLE);
  assign ld_req = req_valid && idle && acc_ok;
  assign reject = req_valid && idle && !acc_ok;
  assign cap_en = (state_q == ST_CAP);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (ld_req) state_d = ST_ADDR;
      ST_ADDR: state_d = ST_RD;
      ST_RD:   state_d = ST_CAP;
      ST_CAP:  state_d = wr_q ? ST_WR : ST_CLR;
      ST_WR:   state_d = ST_WAIT;
      ST_WAIT: if (wait_done) state_d = ST_CLR;
      ST_CLR:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    resp_valid_d  = reject || (state_q == ST_CLR);
    resp_status_d = reject ? STAT_NOT_FOUND : STAT_OK;
    resp_rdata_d  = ((state_q == ST_CLR) && !wr_q) ? rd_ext : '0;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q       <= ST_IDLE;
      resp_valid_q  <= 1'b0;
      resp_status_q <= STAT_OK;
      resp_rdata_q  <= '0;
    end else begin
      state_q       <= state_d;
      resp_valid_q  <= resp_valid_d;
      resp_status_q <= resp_status_d;
      resp_rdata_q  <= resp_rdata_d;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      wr_q    <= 1'b0;
      off_q   <= '0;
      size_q  <= SZ_WORD;
      wdata_q <= '0;
      ctl_q   <= '0;
    end else if (ld_req) begin
      wr_q    <= req_write;
      off_q   <= req_where[1:0];
      size_q  <= acc_size_t'(req_size);
      wdata_q <= req_wdata;
      ctl_q   <= ctl_word;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)     dw_q <= '0;
    else if (cap_en) dw_q <= win_rd_data;
  end

  assign busy        = !idle;
  assign resp_valid  = resp_valid_q;
  assign resp_status = resp_status_q;
  assign resp_rdata  = resp_rdata_q;
  assign ctl_wr_en   = (state_q == ST_ADDR) || (state_q == ST_CLR);
  assign ctl_wr_data = (state_q == ST_ADDR) ? ctl_q : '0;
  assign win_rd_en   = (state_q == ST_RD);
  assign win_wr_en   = (state_q == ST_WR);
  assign win_wr_data = wr_merged;

  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!arst_n)
    (req_valid && idle && !acc_ok) |=> (resp_valid && resp_status && !busy)); // R1
  AST_CTL_FLAGS: assert property (@(posedge clk) disable iff (!arst_n)
    (ctl_wr_en && (ctl_wr_data != '0)) |-> (ctl_wr_data[CW_USE_BIT] && ctl_wr_data[CW_SEL_BIT])); // R2
  AST_CAP_AFTER_READ: assert property (@(posedge clk) disable iff (!arst_n)
    (state_q == ST_CAP) |-> $past(win_rd_en)); // R4
  AST_CLEAR_BEFORE_RESP: assert property (@(posedge clk) disable iff (!arst_n)
    (resp_valid && !resp_status) |-> $past(ctl_wr_en && (ctl_wr_data == '0))); // R4
  AST_WB_ONLY_WRITE: assert property (@(posedge clk) disable iff (!arst_n)
    win_wr_en |-> wr_q); // R5
  AST_BUSY_NO_REFUSE: assert property (@(posedge clk) disable iff (!arst_n)
    busy |=> !(resp_valid && resp_status)); // R9

endmodule

// File: tb/cfg_cycle_seq_tb.sv
module cfg_cycle_seq_tb;

  localparam int unsigned CLK_HZ = 125_000_000;
  localparam int unsigned WAIT_US = 1;
  localparam int WAIT_N = 125;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic        req_type1;
  logic [7:0]  req_slot;
  logic [7:0]  req_func;
  logic [9:0]  req_where;
  logic [1:0]  req_size;
  logic [31:0] req_wdata;
  logic        busy;
  logic        resp_valid;
  logic        resp_status;
  logic [31:0] resp_rdata;
  logic        ctl_wr_en;
  logic [31:0] ctl_wr_data;
  logic        win_rd_en;
  logic [31:0] win_rd_data;
  logic        win_wr_en;
  logic [31:0] win_wr_data;

  cfg_cycle_seq #(.CLK_HZ(CLK_HZ), .WAIT_US(WAIT_US)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_type1(req_type1),
    .req_slot(req_slot), .req_func(req_func), .req_where(req_where),
    .req_size(req_size), .req_wdata(req_wdata),
    .busy(busy), .resp_valid(resp_valid), .resp_status(resp_status),
    .resp_rdata(resp_rdata),
    .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .win_rd_en(win_rd_en), .win_rd_data(win_rd_data),
    .win_wr_en(win_wr_en), .win_wr_data(win_wr_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // data window model with one cycle read latency
  logic [31:0] win_mem = 32'h0;
  logic        preload_en = 1'b0;
  logic [31:0] preload_val = 32'h0;
  always @(posedge clk) begin
    if (preload_en) win_mem <= preload_val;
    else if (win_wr_en) win_mem <= win_wr_data;
    if (win_rd_en) win_rd_data <= win_mem;
  end

  // activity log, sampled 2 ns after each rising edge
  logic        log_clr = 1'b0;
  int          n_ctl, n_rd, n_wr, n_resp;
  logic [31:0] ctl_log [4];
  int          ctl_cyc [4];
  logic [31:0] wr_data;
  int          wr_cyc, resp_cyc;
  logic        got_resp, resp_st;
  logic [31:0] resp_dat;

  always @(posedge clk) begin
    #2;
    if (log_clr) begin
      n_ctl = 0; n_rd = 0; n_wr = 0; n_resp = 0;
      got_resp = 1'b0; resp_st = 1'b0; resp_dat = '0;
      wr_data = '0; wr_cyc = 0; resp_cyc = 0;
      for (int i = 0; i < 4; i++) begin ctl_log[i] = '0; ctl_cyc[i] = 0; end
    end else begin
      if (ctl_wr_en) begin
        if (n_ctl < 4) begin ctl_log[n_ctl] = ctl_wr_data; ctl_cyc[n_ctl] = cyc; end
        n_ctl++;
      end
      if (win_rd_en) n_rd++;
      if (win_wr_en) begin n_wr++; wr_data = win_wr_data; wr_cyc = cyc; end
      if (resp_valid) begin
        n_resp++; got_resp = 1'b1; resp_st = resp_status;
        resp_dat = resp_rdata; resp_cyc = cyc;
      end
    end
  end

  int n_chk = 0;
  int n_fail = 0;
  int req_cyc = 0;
  logic wd_hit = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_ctl(input int slot, input int func, input int rg, input bit t1);
    return 32'h8000_0000 | 32'h4000_0000 | 32'(slot << 11) | 32'(func << 8) | 32'(rg << 2) | 32'(t1);
  endfunction

  task automatic run_req(input bit w, input bit t1, input logic [7:0] slot, input logic [7:0] func,
                         input logic [9:0] where, input logic [1:0] sz, input logic [31:0] wd,
                         input logic [31:0] pre, input bit intr);
    @(negedge clk);
    preload_en = 1'b1; preload_val = pre; log_clr = 1'b1;
    @(negedge clk);
    preload_en = 1'b0; log_clr = 1'b0;
    req_valid = 1'b1; req_write = w; req_type1 = t1; req_slot = slot;
    req_func = func; req_where = where; req_size = sz; req_wdata = wd;
    req_cyc = cyc;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 2000 && !got_resp; i++) begin
      @(negedge clk);
      if (intr && i == 8) begin
        req_valid = 1'b1; req_write = 1'b0; req_slot = 8'd1;
      end else begin
        req_valid = 1'b0;
      end
    end
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10 reset busy", 32'(busy), 32'd0);
    chk("R10 reset resp_valid", 32'(resp_valid), 32'd0);
    chk("R10 reset strobes", {29'd0, ctl_wr_en, win_rd_en, win_wr_en}, 32'd0);
  endtask

  task automatic t_read_word();
    run_req(1'b0, 1'b0, 8'd3, 8'd2, 10'h008, 2'd2, 32'h0, 32'hA1B2C3D4, 1'b0);
    chk("R2 control word", ctl_log[0], exp_ctl(3, 2, 2, 1'b0));
    chk("R4 clear word", ctl_log[1], 32'h0);
    chk("R4 control writes", 32'(n_ctl), 32'd2);
    chk("R4 window reads", 32'(n_rd), 32'd1);
    chk("R4 no window write", 32'(n_wr), 32'd0);
    chk("R4 clear timing", 32'(ctl_cyc[1] - ctl_cyc[0]), 32'd3);
    chk("R4 response timing", 32'(resp_cyc - req_cyc), 32'd5);
    chk("R7 dword data", resp_dat, 32'hA1B2C3D4);
    chk("R10 ok status", 32'(resp_st), 32'd0);
    chk("R10 single pulse", 32'(n_resp), 32'd1);
  endtask

  task automatic t_read_lanes();
    run_req(1'b0, 1'b0, 8'd3, 8'd0, 10'h00C, 2'd0, 32'h0, 32'hA1B2C3D4, 1'b0);
    chk("R7 byte off0", resp_dat, 32'h000000D4);
    run_req(1'b0, 1'b0, 8'd3, 8'd0, 10'h00D, 2'd0, 32'h0, 32'hA1B2C3D4, 1'b0);
    chk("R7 byte off1", resp_dat, 32'h000000C3);
    run_req(1'b0, 1'b0, 8'd3, 8'd0, 10'h00E, 2'd1, 32'h0, 32'hA1B2C3D4, 1'b0);
    chk("R7 half off2", resp_dat, 32'h0000A1B2);
    run_req(1'b0, 1'b0, 8'd3, 8'd0, 10'h00F, 2'd1, 32'h0, 32'hA1B2C3D4, 1'b0);
    chk("R7 half off3 no wrap", resp_dat, 32'h000000A1);
    run_req(1'b0, 1'b0, 8'd3, 8'd0, 10'h00F, 2'd3, 32'h0, 32'h5566_7788, 1'b0);
    chk("R7 size3 full dword", resp_dat, 32'h55667788);
  endtask

  task automatic t_type1_edges();
    run_req(1'b0, 1'b1, 8'd31, 8'd7, 10'h0FC, 2'd2, 32'h0, 32'h0BAD_F00D, 1'b0);
    chk("R3 type1 control word", ctl_log[0], exp_ctl(31, 7, 63, 1'b1));
    chk("R1 max fields accepted", 32'(resp_st), 32'd0);
    chk("R1 max fields data", resp_dat, 32'h0BADF00D);
  endtask

  task automatic t_write();
    run_req(1'b1, 1'b0, 8'd4, 8'd1, 10'h016, 2'd0, 32'h0000_01F5, 32'h11223344, 1'b0);
    chk("R8 byte merge masks upper", wr_data, 32'h11F53344);
    chk("R5 one read", 32'(n_rd), 32'd1);
    chk("R5 one write", 32'(n_wr), 32'd1);
    chk("R5 control word", ctl_log[0], exp_ctl(4, 1, 5, 1'b0));
    chk("R5 clear word", ctl_log[1], 32'h0);
    chk("R5 blind wait", 32'(ctl_cyc[1] - wr_cyc), 32'(WAIT_N + 1));
    chk("R5 response timing", 32'(resp_cyc - req_cyc), 32'(WAIT_N + 6));
    chk("R10 write data zero", resp_dat, 32'h0);
    chk("R10 write status", 32'(resp_st), 32'd0);
    chk("R8 window updated", win_mem, 32'h11F53344);
    run_req(1'b1, 1'b0, 8'd4, 8'd1, 10'h015, 2'd1, 32'hFFFF_BEEF, 32'h11F53344, 1'b0);
    chk("R8 half off1 merge", wr_data, 32'h11BEEF44);
    run_req(1'b1, 1'b0, 8'd4, 8'd1, 10'h017, 2'd1, 32'h0000_ABCD, 32'h11223344, 1'b0);
    chk("R8 half off3 no wrap", wr_data, 32'hCD223344);
    run_req(1'b1, 1'b0, 8'd4, 8'd1, 10'h017, 2'd2, 32'hDEAD_BEEF, 32'h11223344, 1'b0);
    chk("R8 dword write", wr_data, 32'hDEADBEEF);
  endtask

  task automatic t_reject();
    run_req(1'b0, 1'b1, 8'd32, 8'd0, 10'h000, 2'd2, 32'h0, 32'h1, 1'b0);
    chk("R1 slot 32 status", 32'(resp_st), 32'd1);
    chk("R1 slot 32 no strobes", 32'(n_ctl + n_rd + n_wr), 32'd0);
    chk("R1 refusal timing", 32'(resp_cyc - req_cyc), 32'd1);
    run_req(1'b1, 1'b0, 8'd2, 8'd8, 10'h000, 2'd2, 32'h5, 32'h1, 1'b0);
    chk("R1 func 8 status", 32'(resp_st), 32'd1);
    chk("R1 func 8 window kept", win_mem, 32'h1);
    chk("R1 func 8 no strobes", 32'(n_ctl + n_rd + n_wr), 32'd0);
    run_req(1'b0, 1'b0, 8'd2, 8'd0, 10'h100, 2'd2, 32'h0, 32'h1, 1'b0);
    chk("R1 reg 64 status", 32'(resp_st), 32'd1);
    run_req(1'b0, 1'b0, 8'd20, 8'd0, 10'h000, 2'd2, 32'h0, 32'h1, 1'b0);
    chk("R6 reserved slot type0 status", 32'(resp_st), 32'd1);
    chk("R6 reserved slot type0 no strobes", 32'(n_ctl), 32'd0);
    run_req(1'b0, 1'b1, 8'd20, 8'd0, 10'h000, 2'd2, 32'h0, 32'h77, 1'b0);
    chk("R6 reserved slot type1 status", 32'(resp_st), 32'd0);
    chk("R6 reserved slot type1 data", resp_dat, 32'h77);
  endtask

  task automatic t_busy();
    run_req(1'b1, 1'b0, 8'd6, 8'd0, 10'h004, 2'd2, 32'h1234_5678, 32'h0, 1'b1);
    chk("R9 single response", 32'(n_resp), 32'd1);
    chk("R9 control writes", 32'(n_ctl), 32'd2);
    chk("R9 window reads", 32'(n_rd), 32'd1);
    chk("R9 window content", win_mem, 32'h12345678);
    chk("R9 idle after", 32'(busy), 32'd0);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk + int'(wd_hit), n_fail + int'(wd_hit));
  endtask

  initial begin
    #(8 * 150000);
    wd_hit = 1'b1;
    $display("FAIL R10 watchdog: actual hung expected response");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_type1 = 1'b0;
    req_slot = '0; req_func = '0; req_where = '0; req_size = '0; req_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_read_word();
    t_read_lanes();
    t_type1_edges();
    t_write();
    t_reject();
    t_busy();
    report();
    $finish;
  end

endmodule